// File: doc/BRIEF.md
# Fractional Audio Clock Generator

This block turns one fast system clock into the two slower clocks an audio serial port needs. The first stage is a fractional rate stage. An 8-bit multiplier value X and an 8-bit divisor value Y set the audio master clock to f_clk·X/(2·Y). The second stage is an integer divider. It produces the serial bit clock by dividing the master clock by (B+1), where B is a 6-bit value.

Both clocks are produced as register outputs in the system clock domain. Two single-cycle strobes come with them: one marks a master clock rise, the other marks a bit clock fall. Downstream shift logic can use these strobes as enables. A transmit path and a receive path each use their own instance.

The bit rate needed is the sample rate × the bits per sample × the channel count. For example, 16-bit stereo at 48 kHz needs 1.536 MHz.

Top module: `audio_clkgen`

## Requirements
- R1: After reset, mclk, bclk, mclk_tick and bclk_tick are 0 and the internal settings are 0, so no clock toggles until nonzero X and Y are applied.
- R2: The stage keeps a residue. On each system clock cycle it adds X to the residue. When the result is Y or more, Y is subtracted and mclk toggles. So for X ≤ Y, mclk makes floor(N·X/Y) transitions in N cycles, which is a frequency of f_clk·X/(2·Y).
- R3: When the active X or the active Y is 0, mclk stays low and the residue is cleared. An X or Y of 0 that is applied while mclk is running takes effect at the next falling edge of mclk, and mclk then stays low.
- R4: When X ≥ Y (both nonzero), mclk toggles on every system clock cycle, which gives f_clk/2. If more than one Y is left after the subtraction, the residue is cleared to 0.
- R5: For an active bit value B, bclk is high for B+1 master half periods and then low for B+1 master half periods. A rise of bclk always happens in the same cycle as a rise of mclk, and bclk changes only in cycles where mclk changes.
- R6: When B is 0, bclk equals mclk in every cycle.
- R7: New X and Y inputs are adopted only while the stage is stopped or in the cycle where mclk falls. If the residue is Y or more for the newly adopted Y, the residue is cleared. A new B is adopted only when the bit period is at its start, which is a half-period count of 0 with bclk low.
- R8: mclk_tick is high for exactly the one cycle in which mclk has just risen.
- R9: bclk_tick is high for exactly the one cycle in which bclk has just fallen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_mul | input | FRAC_W (8) | Multiplier X of the master rate |
| rate_div | input | FRAC_W (8) | Divisor Y of the master rate |
| bit_div | input | DIV_W (6) | Bit clock divide value B; the divide ratio is B+1 |
| mclk | output | 1 | Master clock |
| bclk | output | 1 | Bit clock |
| mclk_tick | output | 1 | One-cycle strobe on each mclk rise |
| bclk_tick | output | 1 | One-cycle strobe on each bclk fall |

## Verification
The hardest case to reach is a setting change that arrives in the middle of a period. It must not shorten the phase that is running. To reach it, the bench waits until it sees mclk rise or bclk rise, and only then drives a new X, Y or B. It then measures the high and low run lengths around the change.

Stopping from a running state is reached the same way. X or Y is set to zero mid-period, and the bench then checks that mclk settles low and both clocks stay frozen.

A cycle-accurate reference model in the bench predicts every output in every cycle, so each boundary rule is also checked cycle by cycle.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  // Residue left after one rate step has overflowed. If more than one
  // divisor remains (multiplier above divisor), clear it so that the
  // stage toggles every cycle and never runs ahead.
  function automatic logic [15:0] frac_residue(input logic [15:0] sum,
                                               input logic [15:0] den);
    logic [15:0] rem;
    rem = sum - den;
    return (rem >= den) ? 16'd0 : rem;
  endfunction

  // Number of master half periods in one bit clock period.
  function automatic logic [15:0] half_periods(input logic [15:0] div_val);
    return (div_val + 16'd1) << 1;
  endfunction

endpackage

// File: rtl/acg_frac.sv
module acg_frac
  import audio_clkgen_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mul_in,
  input  logic [W-1:0] div_in,
  output logic         mclk,
  output logic         mclk_tick,
  output logic         toggle,
  output logic         running,
  output logic [W-1:0] acc_out,
  output logic [W-1:0] den_out
);

  logic [W-1:0] mul_q, den_q, acc_q;
  logic         mclk_q, tick_q;
  logic [W:0]   sum;
  logic [W-1:0] acc_step;
  logic         tog, fall, load, run_w;

  always_comb begin
    run_w    = (|mul_q) && (|den_q);
    sum      = {1'b0, acc_q} + {1'b0, mul_q};
    tog      = run_w && (sum >= {1'b0, den_q});
    acc_step = tog ? W'(frac_residue(16'(sum), 16'(den_q))) : sum[W-1:0];
    fall     = tog && mclk_q;
    load     = !run_w || fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mul_q  <= '0;
      den_q  <= '0;
      acc_q  <= '0;
      mclk_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      mclk_q <= mclk_q ^ tog;
      tick_q <= tog && !mclk_q;
      if (load) begin
        mul_q <= mul_in;
        den_q <= div_in;
      end
      if (!run_w)
        acc_q <= '0;
      else if (fall)
        acc_q <= (acc_step >= div_in) ? '0 : acc_step;
      else
        acc_q <= acc_step;
    end
  end

  assign mclk      = mclk_q;
  assign mclk_tick = tick_q;
  assign toggle    = tog;
  assign running   = run_w;
  assign acc_out   = acc_q;
  assign den_out   = den_q;

endmodule

// File: rtl/acg_bdiv.sv
module acg_bdiv
  import audio_clkgen_pkg::*;
#(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div_in,
  input  logic          m_toggle,
  output logic          bclk,
  output logic          bclk_tick,
  output logic [DW-1:0] div_act
);

  localparam int CW = DW + 1;

  logic [CW-1:0] cnt_q, cnt_last, cnt_mid;
  logic [DW-1:0] div_q, div_eff;
  logic          bclk_q, bclk_nxt, tick_q, at_start;

  always_comb begin
    at_start = (cnt_q == '0) && !bclk_q;
    div_eff  = at_start ? div_in : div_q;
    cnt_last = CW'(half_periods(16'(div_eff)) - 16'd1);
    cnt_mid  = CW'(div_eff) + CW'(1);
    bclk_nxt = bclk_q;
    if (m_toggle) begin
      if (cnt_q == '0)
        bclk_nxt = 1'b1;
      else if (cnt_q == cnt_mid)
        bclk_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      div_q  <= '0;
      bclk_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= div_eff;
      bclk_q <= bclk_nxt;
      tick_q <= bclk_q && !bclk_nxt;
      if (m_toggle)
        cnt_q <= (cnt_q == cnt_last) ? '0 : cnt_q + CW'(1);
    end
  end

  assign bclk      = bclk_q;
  assign bclk_tick = tick_q;
  assign div_act   = div_q;

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int FRAC_W = 8,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] rate_mul,
  input  logic [FRAC_W-1:0] rate_div,
  input  logic [DIV_W-1:0]  bit_div,
  output logic              mclk,
  output logic              bclk,
  output logic              mclk_tick,
  output logic              bclk_tick
);

  // Internal events brought out for the checker.
  logic              m_toggle;
  logic              m_run;
  logic [FRAC_W-1:0] m_acc;
  logic [FRAC_W-1:0] m_den;
  logic [DIV_W-1:0]  b_div;

  acg_frac #(.W(FRAC_W)) u_frac (
    .clk       (clk),
    .rst_n     (rst_n),
    .mul_in    (rate_mul),
    .div_in    (rate_div),
    .mclk      (mclk),
    .mclk_tick (mclk_tick),
    .toggle    (m_toggle),
    .running   (m_run),
    .acc_out   (m_acc),
    .den_out   (m_den)
  );

  acg_bdiv #(.DW(DIV_W)) u_bdiv (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_in    (bit_div),
    .m_toggle  (m_toggle),
    .bclk      (bclk),
    .bclk_tick (bclk_tick),
    .div_act   (b_div)
  );

endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int FRAC_W = 8,
  parameter int DIV_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mclk,
  input logic              bclk,
  input logic              mclk_tick,
  input logic              bclk_tick,
  input logic              m_run,
  input logic [FRAC_W-1:0] m_acc,
  input logic [FRAC_W-1:0] m_den,
  input logic [DIV_W-1:0]  b_div
);

  // R3
  stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !m_run |-> !mclk);

  // R2
  residue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_run |-> (m_acc < m_den));

  // R7
  cfg_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_den != $past(m_den)) |-> ($past(!m_run) || $fell(mclk)));

  // R8
  mtick_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_tick |-> (mclk && !$past(mclk)));

  // R8
  rise_gives_mtick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mclk) |-> mclk_tick);

  // R9
  btick_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_tick |-> (!bclk && $past(bclk)));

  // R9
  fall_gives_btick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bclk) |-> bclk_tick);

  // R5
  bclk_on_mclk_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk != $past(bclk)) |-> (mclk != $past(mclk)));

  // R5
  brise_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> $rose(mclk));

  // R6
  follow_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_div == '0) |-> (bclk == mclk));

endmodule

bind audio_clkgen audio_clkgen_chk #(.FRAC_W(FRAC_W), .DIV_W(DIV_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mclk      (mclk),
  .bclk      (bclk),
  .mclk_tick (mclk_tick),
  .bclk_tick (bclk_tick),
  .m_run     (m_run),
  .m_acc     (m_acc),
  .m_den     (m_den),
  .b_div     (b_div)
);

// File: tb/audio_clkgen_test.sv
module audio_clkgen_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rate_mul = '0;
  logic [7:0] rate_div = '0;
  logic [5:0] bit_div = '0;
  logic       mclk, bclk, mclk_tick, bclk_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  audio_clkgen uut (
    .clk(clk), .rst_n(rst_n), .rate_mul(rate_mul), .rate_div(rate_div),
    .bit_div(bit_div), .mclk(mclk), .bclk(bclk),
    .mclk_tick(mclk_tick), .bclk_tick(bclk_tick)
  );

  // ---------------- reference model (driver side of the scoreboard) -------
  int mx = 0, my = 0, ma = 0, mbr = 0, bc = 0;
  bit mm = 0, mb = 0;
  logic [3:0] expq[$];

  always @(posedge clk) begin
    bit tog, stopped, nb, mt, bt, at_start;
    if (!rst_n) begin
      mx = 0; my = 0; ma = 0; mbr = 0; bc = 0; mm = 0; mb = 0;
      expq.push_back(4'b0000);
    end else begin
      stopped  = (mx == 0) || (my == 0);
      at_start = (bc == 0) && !mb;
      if (at_start) mbr = int'(bit_div);
      tog = 0;
      if (stopped) begin
        mx = int'(rate_mul); my = int'(rate_div); ma = 0;
      end else begin
        ma = ma + mx;
        if (ma >= my) begin
          tog = 1;
          ma  = ma - my;
          if (ma >= my) ma = 0;
        end
        if (tog && mm) begin
          mx = int'(rate_mul); my = int'(rate_div);
          if (ma >= my) ma = 0;
        end
      end
      nb = mb;
      if (tog) begin
        if (bc == 0) nb = 1;
        else if (bc == mbr + 1) nb = 0;
        bc = (bc == 2 * mbr + 1) ? 0 : bc + 1;
      end
      mt = tog && !mm;
      bt = mb && !nb;
      mm = mm ^ tog;
      mb = nb;
      expq.push_back({mm, mb, mt, bt});
    end
  end

  // ---------------- monitor ----------------------------------------------
  always @(negedge clk) begin
    logic [3:0] e;
    if (expq.size() > 0) begin
      e = expq.pop_front();
      checks++;
      if (mclk !== e[3]) begin
        fails++; $display("FAIL R2 mclk actual=%b expected=%b @%0t", mclk, e[3], $time);
      end
      if (bclk !== e[2]) begin
        fails++; $display("FAIL R5 bclk actual=%b expected=%b @%0t", bclk, e[2], $time);
      end
      if (mclk_tick !== e[1]) begin
        fails++; $display("FAIL R8 mclk_tick actual=%b expected=%b @%0t", mclk_tick, e[1], $time);
      end
      if (bclk_tick !== e[0]) begin
        fails++; $display("FAIL R9 bclk_tick actual=%b expected=%b @%0t", bclk_tick, e[0], $time);
      end
    end
  end

  // ---------------- helpers ----------------------------------------------
  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic check_near(input string req, input int act, input int exp_v);
    checks++;
    if (act < exp_v - 1 || act > exp_v + 1) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (+/-1)", req, act, exp_v);
    end
  endtask

  // Counts mclk transitions, bclk rises and tick pulses over n cycles.
  task automatic observe(input int n, output int m_tr, output int b_rise,
                         output int m_ticks, output int b_ticks, output int m_rise);
    bit pm, pb;
    m_tr = 0; b_rise = 0; m_ticks = 0; b_ticks = 0; m_rise = 0;
    @(negedge clk);
    pm = mclk; pb = bclk;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (mclk != pm) m_tr++;
      if (mclk && !pm) m_rise++;
      if (bclk && !pb) b_rise++;
      if (mclk_tick) m_ticks++;
      if (bclk_tick) b_ticks++;
      pm = mclk; pb = bclk;
    end
  endtask

  task automatic wait_level(input bit sig_b, input bit lvl);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if ((sig_b ? bclk : mclk) == lvl) return;
    end
  endtask

  task automatic run_length(input bit sig_b, input bit lvl, output int len);
    len = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if ((sig_b ? bclk : mclk) != lvl) return;
      len++;
    end
  endtask

  // ---------------- stimulus ---------------------------------------------
  initial begin
    int tr, br, mt, bt, mr, len, frozen;
    bit b0;
    repeat (4) @(negedge clk);
    // R1: outputs low in reset and after release with zero settings
    check("R1 mclk", int'(mclk), 0);
    check("R1 bclk", int'(bclk), 0);
    rst_n = 1'b1;
    observe(30, tr, br, mt, bt, mr);
    check("R1 no toggles with zero settings", tr, 0);

    // R2 and R6: X=1, Y=4, B=0
    rate_mul = 8'd1; rate_div = 8'd4; bit_div = 6'd0;
    observe(400, tr, br, mt, bt, mr);
    check_near("R2 transitions X=1 Y=4", tr, 100);
    check_near("R6 bclk rises equal mclk rises", br, mr);
    check("R8 tick count equals rises", mt, mr);

    // R2 and R5: X=3, Y=7, B=2
    rate_mul = 8'd3; rate_div = 8'd7; bit_div = 6'd2;
    observe(50, tr, br, mt, bt, mr);
    observe(840, tr, br, mt, bt, mr);
    check_near("R2 transitions X=3 Y=7", tr, 360);
    check_near("R5 bclk rises for B=2", br, 60);
    check_near("R9 tick count equals bclk periods", bt, br);

    // R4: X above Y toggles every cycle
    rate_mul = 8'd9; rate_div = 8'd5;
    observe(30, tr, br, mt, bt, mr);
    observe(100, tr, br, mt, bt, mr);
    check("R4 toggle every cycle", tr, 100);

    // R5: odd divisor B=4 with mclk at f_clk/2 gives 5 high / 5 low
    rate_mul = 8'd1; rate_div = 8'd1; bit_div = 6'd4;
    observe(60, tr, br, mt, bt, mr);
    wait_level(1'b1, 1'b0);
    wait_level(1'b1, 1'b1);
    run_length(1'b1, 1'b1, len);
    check("R5 bclk high length B=4", len, 5);
    run_length(1'b1, 1'b0, len);
    check("R5 bclk low length B=4", len, 5);

    // R7: change Y right after a master rise; high phase keeps old length
    bit_div = 6'd0;
    rate_mul = 8'd1; rate_div = 8'd8;
    observe(80, tr, br, mt, bt, mr);
    wait_level(1'b0, 1'b0);
    wait_level(1'b0, 1'b1);
    rate_div = 8'd2;
    run_length(1'b0, 1'b1, len);
    check("R7 high phase uses old Y", len - 1, 7);
    run_length(1'b0, 1'b0, len);
    check("R7 low phase uses new Y", len, 2);

    // R7: change B mid bit period; current period keeps old split
    rate_mul = 8'd1; rate_div = 8'd1; bit_div = 6'd3;
    observe(40, tr, br, mt, bt, mr);
    wait_level(1'b1, 1'b0);
    wait_level(1'b1, 1'b1);
    bit_div = 6'd1;
    run_length(1'b1, 1'b1, len);
    check("R7 bclk high keeps old B", len, 4);
    run_length(1'b1, 1'b0, len);
    check("R7 bclk low keeps old B", len, 4);
    run_length(1'b1, 1'b1, len);
    check("R7 next bclk high uses new B", len, 2);

    // R3: zero X stops the master clock low
    rate_mul = 8'd2; rate_div = 8'd5; bit_div = 6'd1;
    observe(60, tr, br, mt, bt, mr);
    rate_mul = 8'd0;
    observe(20, tr, br, mt, bt, mr);
    b0 = bclk;
    check("R3 mclk low after X=0", int'(mclk), 0);
    frozen = 1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (mclk || bclk != b0 || mclk_tick || bclk_tick) frozen = 0;
    end
    check("R3 clocks frozen with X=0", frozen, 1);

    // R3: zero Y stops as well
    rate_mul = 8'd3; rate_div = 8'd4;
    observe(40, tr, br, mt, bt, mr);
    check("R3 restart after stop", int'(tr > 0), 1);
    rate_div = 8'd0;
    observe(20, tr, br, mt, bt, mr);
    observe(50, tr, br, mt, bt, mr);
    check("R3 no toggles with Y=0", tr, 0);
    check("R3 mclk low with Y=0", int'(mclk), 0);

    done = 1'b1;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // ---------------- watchdog ---------------------------------------------
  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule